// File: doc/BRIEF.md
# Accumulator Execution Unit Datapath

This block is the data-manipulation core of one execution unit. It holds a word-wide accumulator together with a carry flag and a zero flag. Every clock cycle it accepts one decoded instruction and carries it out on unsigned operands. The accumulator is always the first operand and, for most operations, the destination. The second operand comes from a two-level multiplexer. At the first level, one shared select field picks a lane from the register bus, which carries the peer registers, and the same lane from the data bus, which carries the immediate, load buffer, stack and input port. At the second level, a single bit chooses between those two picks.

Four operating subunits each work out a candidate result and a raw carry out:
- an adder/subtracter;
- a logic unit;
- a left shifter, which also performs increment, decrement and negate;
- a right shifter, which also performs bitwise NOT.

A carry-out selector picks the carry of the active subunit. It inverts that carry for the subtract family, for decrement and for negate, so that the carry flag reads as a borrow. Three load bits in the instruction decide independently whether the accumulator, the carry flag and the zero flag take their new values.

The word width `W` is a multiple of 4, from 4 to 16. `NSRC` sets the number of lanes on each operand bus. In the text below, A is the accumulator, B is the selected operand and c is the current carry flag.

Top module: `eu_accum`

## Requirements
- R1: While `rst_n` is low, `acc_o`, `cf_o` and `zf_o` are all 0. Reset is asynchronous.
- R2: When `dsel_i`=0 the operand B is lane `sel_i` of `reg_bus_i`, and when `dsel_i`=1 it is lane `sel_i` of `dat_bus_i`. Lane k occupies bits [k*W +: W].
- R3: ADD (op 0) computes A+B and ADC (op 1) computes A+B+c. The carry flag takes the carry out of bit W-1.
- R4: SUB (op 2) computes A-B and SBB (op 3) computes A-B-c. The carry flag takes the borrow, which is the inverted adder carry.
- R5: CMP (op 4) sets the flags exactly as SUB does, and TEST (op 8) sets the flags exactly as AND does. Both leave the accumulator unchanged even when `ld_acc_i` is 1.
- R6: AND (op 5), OR (op 6), XOR (op 7) and NOT (op 9, which computes ~A) clear the carry flag. TEST (op 8) also clears it.
- R7: The one-bit shifts take the bit shifted out into the carry flag:
  - SHL (op 10) and SAL (op 11) shift left and fill with 0;
  - SHR (op 12) shifts right and fills with 0;
  - SAR (op 13) shifts right and fills with the old MSB.
- R8: The one-bit rotates take the bit moved out of the word into the carry flag:
  - ROL (op 14) and ROR (op 15) rotate the word by one bit;
  - RCL (op 16) and RCR (op 17) rotate through the carry, so the old c enters the vacated bit.
- R9: INC (op 18) computes A+1, with carry set when A was all ones. DEC (op 19) computes A-1, with carry set when A was 0. NEG (op 20) computes 0-A, with carry set when A was nonzero.
- R10: When `ld_zf_i` is 1, the zero flag becomes 1 exactly when the operation's result is 0. This applies to CMP and TEST as well.
- R11: Each load bit gates its own register. When `ld_acc_i`, `ld_cf_i` or `ld_zf_i` is 0, the accumulator, carry flag or zero flag respectively keeps its value.
- R12: Opcodes 21 to 31 change neither the accumulator nor either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| ld_acc_i | input | 1 | Accumulator write enable |
| ld_cf_i | input | 1 | Carry flag update enable |
| ld_zf_i | input | 1 | Zero flag update enable |
| dsel_i | input | 1 | Second-level operand select: 0 = register bus, 1 = data bus |
| sel_i | input | clog2(NSRC) | Lane select shared by both first-level multiplexers |
| reg_bus_i | input | NSRC*W | Peer register values, one lane each |
| dat_bus_i | input | NSRC*W | Data sources, one lane each |
| acc_o | output | W | Accumulator |
| cf_o | output | 1 | Carry flag |
| zf_o | output | 1 | Zero flag |

## Verification
All state is visible at the ports, so any wrong internal value shows on `acc_o`, `cf_o` or `zf_o` one clock edge after the instruction that caused it. A wrong operand pick, subunit result or carry-in choice appears at once as a bad accumulator or carry value. A missing carry inversion or a load bit that leaks shows as a flag that moved when it should have held, or held when it should have moved. Because every result feeds the next instruction through the accumulator and the carry, a corrupted value also spreads into every check that follows until the operand is reloaded.

// File: rtl/eu_pkg.sv
package eu_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBB  = 5'd3,
    OP_CMP  = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR  = 5'd7,
    OP_TEST = 5'd8,  OP_NOT  = 5'd9,  OP_SHL  = 5'd10, OP_SAL  = 5'd11,
    OP_SHR  = 5'd12, OP_SAR  = 5'd13, OP_ROL  = 5'd14, OP_ROR  = 5'd15,
    OP_RCL  = 5'd16, OP_RCR  = 5'd17, OP_INC  = 5'd18, OP_DEC  = 5'd19,
    OP_NEG  = 5'd20
  } eu_op_e;

  typedef enum logic [2:0] {U_NONE, U_ARITH, U_LOGIC, U_LSH, U_RSH} eu_unit_e;
  typedef enum logic [1:0] {CI_ZERO, CI_ONE, CI_CF, CI_NCF} eu_acin_e;
  typedef enum logic [1:0] {LF_AND, LF_OR, LF_XOR} eu_lfn_e;
  typedef enum logic [1:0] {LM_SHIFT, LM_INC, LM_DEC, LM_NEG} eu_lmode_e;
  typedef enum logic [1:0] {SI_ZERO, SI_MSB, SI_LSB, SI_CF} eu_sin_e;

  typedef struct packed {
    eu_unit_e  unit;    // which subunit drives the result
    logic      sub;     // adder takes the inverted operand
    eu_acin_e  acin;    // adder carry-in source
    eu_lfn_e   lfn;     // logic function
    eu_lmode_e lmode;   // left unit mode
    eu_sin_e   sin;     // bit entering a shifter
    logic      rnot;    // right unit performs NOT
    logic      co_inv;  // carry out read as borrow
    logic      keep;    // result must not reach the accumulator
    logic      valid;   // opcode is defined
  } eu_ctl_t;

endpackage

// File: rtl/eu_decode.sv
module eu_decode
  import eu_pkg::*;
(
  input  logic [4:0] op_i,
  output eu_ctl_t    ctl_o
);

  always_comb begin
    ctl_o        = '0;
    ctl_o.unit   = U_NONE;
    ctl_o.acin   = CI_ZERO;
    ctl_o.lfn    = LF_AND;
    ctl_o.lmode  = LM_SHIFT;
    ctl_o.sin    = SI_ZERO;
    ctl_o.valid  = 1'b1;
    case (op_i)
      OP_ADD:  begin ctl_o.unit = U_ARITH; end
      OP_ADC:  begin ctl_o.unit = U_ARITH; ctl_o.acin = CI_CF; end
      OP_SUB:  begin ctl_o.unit = U_ARITH; ctl_o.sub = 1'b1; ctl_o.acin = CI_ONE; ctl_o.co_inv = 1'b1; end
      OP_SBB:  begin ctl_o.unit = U_ARITH; ctl_o.sub = 1'b1; ctl_o.acin = CI_NCF; ctl_o.co_inv = 1'b1; end
      OP_CMP:  begin ctl_o.unit = U_ARITH; ctl_o.sub = 1'b1; ctl_o.acin = CI_ONE; ctl_o.co_inv = 1'b1;
                     ctl_o.keep = 1'b1; end
      OP_AND:  begin ctl_o.unit = U_LOGIC; ctl_o.lfn = LF_AND; end
      OP_OR:   begin ctl_o.unit = U_LOGIC; ctl_o.lfn = LF_OR; end
      OP_XOR:  begin ctl_o.unit = U_LOGIC; ctl_o.lfn = LF_XOR; end
      OP_TEST: begin ctl_o.unit = U_LOGIC; ctl_o.lfn = LF_AND; ctl_o.keep = 1'b1; end
      OP_NOT:  begin ctl_o.unit = U_RSH; ctl_o.rnot = 1'b1; end
      OP_SHL,
      OP_SAL:  begin ctl_o.unit = U_LSH; ctl_o.sin = SI_ZERO; end
      OP_ROL:  begin ctl_o.unit = U_LSH; ctl_o.sin = SI_MSB; end
      OP_RCL:  begin ctl_o.unit = U_LSH; ctl_o.sin = SI_CF; end
      OP_INC:  begin ctl_o.unit = U_LSH; ctl_o.lmode = LM_INC; end
      OP_DEC:  begin ctl_o.unit = U_LSH; ctl_o.lmode = LM_DEC; ctl_o.co_inv = 1'b1; end
      OP_NEG:  begin ctl_o.unit = U_LSH; ctl_o.lmode = LM_NEG; ctl_o.co_inv = 1'b1; end
      OP_SHR:  begin ctl_o.unit = U_RSH; ctl_o.sin = SI_ZERO; end
      OP_SAR:  begin ctl_o.unit = U_RSH; ctl_o.sin = SI_MSB; end
      OP_ROR:  begin ctl_o.unit = U_RSH; ctl_o.sin = SI_LSB; end
      OP_RCR:  begin ctl_o.unit = U_RSH; ctl_o.sin = SI_CF; end
      default: begin ctl_o.valid = 1'b0; end
    endcase
  end

endmodule

// File: rtl/eu_opmux.sv
module eu_opmux #(
  parameter int unsigned W    = 8,
  parameter int unsigned NSRC = 4,
  parameter int unsigned SELW = 2
) (
  input  logic [NSRC*W-1:0] reg_bus_i,
  input  logic [NSRC*W-1:0] dat_bus_i,
  input  logic [SELW-1:0]   sel_i,
  input  logic              dsel_i,
  output logic [W-1:0]      opnd_o
);

  localparam int unsigned FULL = (NSRC == (1 << SELW)) ? 1 : 0;

  logic [W-1:0] reg_lane [NSRC];
  logic [W-1:0] dat_lane [NSRC];
  logic [W-1:0] reg_pick;
  logic [W-1:0] dat_pick;

  for (genvar k = 0; k < NSRC; k++) begin : g_lane
    assign reg_lane[k] = reg_bus_i[k*W +: W];
    assign dat_lane[k] = dat_bus_i[k*W +: W];
  end

  // First level: both multiplexers share one select.
  if (FULL == 1) begin : g_full
    assign reg_pick = reg_lane[sel_i];
    assign dat_pick = dat_lane[sel_i];
  end else begin : g_part
    always_comb begin
      reg_pick = '0;
      dat_pick = '0;
      for (int k = 0; k < NSRC; k++) begin
        if (sel_i == SELW'(k)) begin
          reg_pick = reg_lane[k];
          dat_pick = dat_lane[k];
        end
      end
    end
  end

  // Second level.
  assign opnd_o = dsel_i ? dat_pick : reg_pick;

endmodule

// File: rtl/eu_oper.sv
module eu_oper
  import eu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cf_i,
  input  eu_ctl_t      ctl_i,
  output logic [W-1:0] res_o,
  output logic         co_o
);

  // Adder / subtracter
  logic [W-1:0] ar_b;
  logic         ar_cin;
  logic [W:0]   ar_sum;

  always_comb begin
    ar_b = ctl_i.sub ? ~b_i : b_i;
    case (ctl_i.acin)
      CI_ONE:  ar_cin = 1'b1;
      CI_CF:   ar_cin = cf_i;
      CI_NCF:  ar_cin = ~cf_i;
      default: ar_cin = 1'b0;
    endcase
    ar_sum = {1'b0, a_i} + {1'b0, ar_b} + {{W{1'b0}}, ar_cin};
  end

  // Logic unit
  logic [W-1:0] lg_res;

  always_comb begin
    case (ctl_i.lfn)
      LF_OR:   lg_res = a_i | b_i;
      LF_XOR:  lg_res = a_i ^ b_i;
      default: lg_res = a_i & b_i;
    endcase
  end

  // Left unit: shift/rotate left, increment, decrement, negate
  logic         ls_in;
  logic [W-1:0] ls_x;
  logic [W-1:0] ls_y;
  logic         ls_c;
  logic [W:0]   ls_sum;
  logic [W-1:0] ls_res;
  logic         ls_co;

  always_comb begin
    case (ctl_i.sin)
      SI_MSB:  ls_in = a_i[W-1];
      SI_LSB:  ls_in = a_i[0];
      SI_CF:   ls_in = cf_i;
      default: ls_in = 1'b0;
    endcase
    ls_x = a_i;
    ls_y = '0;
    ls_c = 1'b0;
    case (ctl_i.lmode)
      LM_INC:  ls_c = 1'b1;
      LM_DEC:  ls_y = '1;
      LM_NEG:  begin ls_x = ~a_i; ls_c = 1'b1; end
      default: ;
    endcase
    ls_sum = {1'b0, ls_x} + {1'b0, ls_y} + {{W{1'b0}}, ls_c};
    if (ctl_i.lmode == LM_SHIFT) begin
      ls_res = {a_i[W-2:0], ls_in};
      ls_co  = a_i[W-1];
    end else begin
      ls_res = ls_sum[W-1:0];
      ls_co  = ls_sum[W];
    end
  end

  // Right unit: shift/rotate right, NOT
  logic         rs_in;
  logic [W-1:0] rs_res;
  logic         rs_co;

  always_comb begin
    case (ctl_i.sin)
      SI_MSB:  rs_in = a_i[W-1];
      SI_LSB:  rs_in = a_i[0];
      SI_CF:   rs_in = cf_i;
      default: rs_in = 1'b0;
    endcase
    if (ctl_i.rnot) begin
      rs_res = ~a_i;
      rs_co  = 1'b0;
    end else begin
      rs_res = {rs_in, a_i[W-1:1]};
      rs_co  = a_i[0];
    end
  end

  // Result and carry-out selection
  logic co_raw;

  always_comb begin
    case (ctl_i.unit)
      U_ARITH: begin res_o = ar_sum[W-1:0]; co_raw = ar_sum[W]; end
      U_LOGIC: begin res_o = lg_res;        co_raw = 1'b0;      end
      U_LSH:   begin res_o = ls_res;        co_raw = ls_co;     end
      U_RSH:   begin res_o = rs_res;        co_raw = rs_co;     end
      default: begin res_o = a_i;           co_raw = cf_i;      end
    endcase
    co_o = co_raw ^ ctl_i.co_inv;
  end

endmodule

// File: rtl/eu_accum.sv
module eu_accum
  import eu_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned NSRC = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [4:0]                            op_i,
  input  logic                                  ld_acc_i,
  input  logic                                  ld_cf_i,
  input  logic                                  ld_zf_i,
  input  logic                                  dsel_i,
  input  logic [((NSRC > 1) ? $clog2(NSRC) : 1)-1:0] sel_i,
  input  logic [NSRC*W-1:0]                     reg_bus_i,
  input  logic [NSRC*W-1:0]                     dat_bus_i,
  output logic [W-1:0]                          acc_o,
  output logic                                  cf_o,
  output logic                                  zf_o
);

  localparam int unsigned SELW = (NSRC > 1) ? $clog2(NSRC) : 1;

  eu_ctl_t      ctl;
  logic [W-1:0] opnd;
  logic [W-1:0] res;
  logic         co;

  logic [W-1:0] acc_q, acc_d;
  logic         cf_q, cf_d;
  logic         zf_q, zf_d;
  logic         acc_en, cf_en, zf_en;

  eu_decode i_dec (
    .op_i  (op_i),
    .ctl_o (ctl)
  );

  eu_opmux #(.W(W), .NSRC(NSRC), .SELW(SELW)) i_mux (
    .reg_bus_i (reg_bus_i),
    .dat_bus_i (dat_bus_i),
    .sel_i     (sel_i),
    .dsel_i    (dsel_i),
    .opnd_o    (opnd)
  );

  eu_oper #(.W(W)) i_oper (
    .a_i   (acc_q),
    .b_i   (opnd),
    .cf_i  (cf_q),
    .ctl_i (ctl),
    .res_o (res),
    .co_o  (co)
  );

  // Next state
  always_comb begin
    acc_en = ctl.valid & ld_acc_i & ~ctl.keep;
    cf_en  = ctl.valid & ld_cf_i;
    zf_en  = ctl.valid & ld_zf_i;
    acc_d  = acc_en ? res : acc_q;
    cf_d   = cf_en ? co : cf_q;
    zf_d   = zf_en ? (res == '0) : zf_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cf_q  <= 1'b0;
      zf_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      cf_q  <= cf_d;
      zf_q  <= zf_d;
    end
  end

  assign acc_o = acc_q;
  assign cf_o  = cf_q;
  assign zf_o  = zf_q;

endmodule

// File: rtl/eu_accum_chk.sv
module eu_accum_chk
  import eu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [4:0]   op_i,
  input logic         ld_acc_i,
  input logic         ld_cf_i,
  input logic         ld_zf_i,
  input logic [W-1:0] acc_o,
  input logic         cf_o,
  input logic         zf_o
);

  logic is_keep, is_clrc, is_bad;
  assign is_keep = (op_i == OP_CMP) || (op_i == OP_TEST);
  assign is_clrc = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR) ||
                   (op_i == OP_TEST) || (op_i == OP_NOT);
  assign is_bad  = (op_i > OP_NEG);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (acc_o == '0 && !cf_o && !zf_o);
    end
  end

  a_r11_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_acc_i |=> $stable(acc_o));

  a_r11_cf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_cf_i |=> $stable(cf_o));

  a_r11_zf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_zf_i |=> $stable(zf_o));

  a_r5_keep_acc: assert property (@(posedge clk) disable iff (!rst_n)
    is_keep |=> $stable(acc_o));

  a_r12_undefined: assert property (@(posedge clk) disable iff (!rst_n)
    is_bad |=> ($stable(acc_o) && $stable(cf_o) && $stable(zf_o)));

  a_r10_zero_track: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_acc_i && ld_zf_i && !is_bad && !is_keep) |=> (zf_o == (acc_o == '0)));

  a_r6_logic_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cf_i && is_clrc) |=> !cf_o);

endmodule

bind eu_accum eu_accum_chk #(.W(W)) u_chk (.*);

// File: tb/test_eu_accum.sv
`timescale 1ns/1ps
module test_eu_accum;

  localparam int unsigned W    = 8;
  localparam int unsigned NSRC = 4;
  localparam int unsigned SELW = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b1;
  logic [4:0]        op;
  logic              lda, ldc, ldz, dsel;
  logic [SELW-1:0]   sel;
  logic [NSRC*W-1:0] rbus, dbus;
  logic [W-1:0]      acc;
  logic              cf, zf;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  logic [W-1:0] m_acc;
  logic         m_cf, m_zf;

  always #2 clk = ~clk;

  eu_accum #(.W(W), .NSRC(NSRC)) i_eu_accum (
    .clk(clk), .rst_n(rst_n), .op_i(op), .ld_acc_i(lda), .ld_cf_i(ldc),
    .ld_zf_i(ldz), .dsel_i(dsel), .sel_i(sel), .reg_bus_i(rbus),
    .dat_bus_i(dbus), .acc_o(acc), .cf_o(cf), .zf_o(zf)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Reference behaviour from the requirements.
  function automatic void ref_exec(input int o, input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic c, output logic [W-1:0] r, output logic co,
                                   output logic wr, output logic ok);
    logic [W:0] t;
    ok = 1'b1; wr = 1'b1; r = a; co = c;
    case (o)
      0:  begin t = {1'b0, a} + {1'b0, b}; r = t[W-1:0]; co = t[W]; end
      1:  begin t = {1'b0, a} + {1'b0, b} + (W+1)'(c); r = t[W-1:0]; co = t[W]; end
      2:  begin r = a - b; co = (a < b); end
      3:  begin r = a - b - W'(c); co = ({1'b0, a} < ({1'b0, b} + (W+1)'(c))); end
      4:  begin r = a - b; co = (a < b); wr = 1'b0; end
      5:  begin r = a & b; co = 1'b0; end
      6:  begin r = a | b; co = 1'b0; end
      7:  begin r = a ^ b; co = 1'b0; end
      8:  begin r = a & b; co = 1'b0; wr = 1'b0; end
      9:  begin r = ~a; co = 1'b0; end
      10, 11: begin r = a << 1; co = a[W-1]; end
      12: begin r = a >> 1; co = a[0]; end
      13: begin r = {a[W-1], a[W-1:1]}; co = a[0]; end
      14: begin r = {a[W-2:0], a[W-1]}; co = a[W-1]; end
      15: begin r = {a[0], a[W-1:1]}; co = a[0]; end
      16: begin r = {a[W-2:0], c}; co = a[W-1]; end
      17: begin r = {c, a[W-1:1]}; co = a[0]; end
      18: begin r = a + 1'b1; co = (a == '1); end
      19: begin r = a - 1'b1; co = (a == '0); end
      20: begin r = '0 - a; co = (a != '0); end
      default: begin ok = 1'b0; wr = 1'b0; end
    endcase
  endfunction

  function automatic string tag_of(input int o);
    case (o)
      0, 1:           return "R3";
      2, 3:           return "R4";
      4, 8:           return "R5";
      5, 6, 7, 9:     return "R6";
      10, 11, 12, 13: return "R7";
      14, 15, 16, 17: return "R8";
      18, 19, 20:     return "R9";
      default:        return "R12";
    endcase
  endfunction

  // One instruction: drive after a falling edge, sample at the next falling edge.
  task automatic run(input int o, input logic la, input logic lc, input logic lz,
                     input logic ds, input int s, input logic [W-1:0] v, input string tg);
    logic [W-1:0] r;
    logic co, wr, ok;
    string t;
    op = 5'(o); lda = la; ldc = lc; ldz = lz; dsel = ds; sel = SELW'(s);
    for (int k = 0; k < NSRC; k++) begin
      rbus[k*W +: W] = W'($urandom);
      dbus[k*W +: W] = W'($urandom);
    end
    if (ds) dbus[s*W +: W] = v; else rbus[s*W +: W] = v;
    ref_exec(o, m_acc, v, m_cf, r, co, wr, ok);
    @(posedge clk);
    @(negedge clk);
    if (ok) begin
      if (la && wr) m_acc = r;
      if (lc) m_cf = co;
      if (lz) m_zf = (r == '0);
    end
    t = (tg != "") ? tg : (!ok ? "R12" : (!la ? "R11" : tag_of(o)));
    chk(t, "acc", int'(acc), int'(m_acc));
    chk(!ok ? "R12" : (!lc ? "R11" : tag_of(o)), "cf", int'(cf), int'(m_cf));
    chk(!ok ? "R12" : (!lz ? "R11" : "R10"), "zf", int'(zf), int'(m_zf));
  endtask

  task automatic load_acc(input logic [W-1:0] v);
    run(5, 1, 1, 1, 1, 0, '0, "");
    run(0, 1, 1, 1, 1, 1, v, "");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    op = '0; lda = 0; ldc = 0; ldz = 0; dsel = 0; sel = '0; rbus = '0; dbus = '0;
    m_acc = '0; m_cf = 0; m_zf = 0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "acc", int'(acc), 0);
    chk("R1", "cf", int'(cf), 0);
    chk("R1", "zf", int'(zf), 0);
    rst_n = 1'b1;

    // R2: operand from each bus and lane, acc starts at 0
    run(0, 1, 1, 1, 0, 2, 8'h5a, "R2");
    run(6, 1, 1, 1, 1, 3, 8'h81, "R2");
    run(7, 1, 1, 1, 0, 1, 8'hdb, "R2");
    run(5, 1, 1, 1, 1, 0, 8'h0f, "R2");

    // R3 carry out and zero
    load_acc(8'hff);
    run(0, 1, 1, 1, 1, 2, 8'h01, "R3");
    run(1, 1, 1, 1, 0, 0, 8'h10, "R3");
    // R4 borrow
    load_acc(8'h00);
    run(2, 1, 1, 1, 1, 1, 8'h01, "R4");
    run(3, 1, 1, 1, 1, 1, 8'h0f, "R4");
    // R5 compare and test with the accumulator load bit set
    load_acc(8'h33);
    run(4, 1, 1, 1, 0, 3, 8'h33, "R5");
    run(4, 1, 1, 1, 0, 3, 8'h34, "R5");
    run(8, 1, 1, 1, 1, 2, 8'hcc, "R5");
    // R6
    run(9, 1, 1, 1, 0, 0, 8'h00, "R6");
    // R7 / R8
    load_acc(8'h81);
    run(13, 1, 1, 1, 0, 0, 8'h00, "R7");
    run(10, 1, 1, 1, 0, 0, 8'h00, "R7");
    load_acc(8'h80);
    run(10, 1, 1, 1, 0, 0, 8'h00, "R7");
    run(16, 1, 1, 1, 0, 0, 8'h00, "R8");
    run(17, 1, 1, 1, 0, 0, 8'h00, "R8");
    run(15, 1, 1, 1, 0, 0, 8'h00, "R8");
    // R9 corners
    load_acc(8'h00);
    run(20, 1, 1, 1, 0, 0, 8'h00, "R9");
    run(19, 1, 1, 1, 0, 0, 8'h00, "R9");
    run(18, 1, 1, 1, 0, 0, 8'h00, "R9");
    run(20, 1, 1, 1, 0, 0, 8'h00, "R9");
    // R11 all load bits clear
    run(0, 0, 0, 0, 1, 0, 8'h77, "R11");
    // R12 undefined opcodes with all loads set
    run(25, 1, 1, 1, 1, 0, 8'h55, "R12");
    run(31, 1, 1, 1, 0, 2, 8'h00, "R12");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int o;
      o = ($urandom % 8 == 0) ? int'($urandom % 32) : int'($urandom % 21);
      run(o, ($urandom % 6) != 0, ($urandom % 6) != 0, ($urandom % 6) != 0,
          1'($urandom), int'($urandom % NSRC), W'($urandom), "");
    end

    // R1 asynchronous reset in mid-run
    load_acc(8'hff);
    run(0, 1, 1, 1, 1, 0, 8'h01, "");
    rst_n = 1'b0;
    #1;
    chk("R1", "acc", int'(acc), 0);
    chk("R1", "cf", int'(cf), 0);
    chk("R1", "zf", int'(zf), 0);
    m_acc = '0; m_cf = 0; m_zf = 0;
    @(negedge clk);
    rst_n = 1'b1;
    run(0, 1, 1, 1, 1, 1, 8'h00, "R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule